// File: doc/BRIEF.md
# Memory-Read Pixel Formatter with Decimation

This block sits behind a memory fetch engine and turns 16-bit words read back from memory into a stream of 14-bit pixels. Each word holds one 16-bit pixel, or two 8-bit pixels in packed mode. Every pixel is aligned to 14 bits with one of seven fixed shift codes. It can then be smoothed by a (1,2,1) horizontal averager and thinned by a fractional horizontal decimator whose output-to-input ratio is 16/N.

All pixel work is paced by a pixel-rate enable. A programmable clock divider produces this enable. A word is taken through a valid/ready handshake, and only on an enable cycle. Each pixel that survives decimation appears on a registered one-cycle valid output. A start-of-line marker travels with the first word of each line and comes out on the first pixel emitted for that line.

Top module: `mrd_pix_fmt`

## Requirements
- R1: Shift code 0 outputs word bits 15:2, code 1 outputs bits 14:1, and code 2 outputs bits 13:0.
- R2: Codes 3, 4, 5 and 6 output bits 12:0, 11:0, 10:0 and 9:0, with 1, 2, 3 and 4 zero bits appended on the right. Code 7 behaves as code 6.
- R3: When packed mode is set, each accepted word yields two pixels in turn: bits 7:0 first, then bits 15:8. Each byte is placed in bits 15:8 of a 16-bit value, with zeros below, before alignment. in_ready is low on the enable cycle that emits the second byte.
- R4: When packed mode is clear, each accepted word yields one pixel: the whole 16-bit word, aligned.
- R5: When averaging is on, the output for aligned pixel p[i] is (p[i-2] + 2*p[i-1] + p[i] + 2) >> 2. At a line start, both history pixels are loaded with the line's first pixel. When averaging is off, p[i] passes through unchanged.
- R6: With decimation on, an accumulator is cleared at each line start, then increases by 16 for every pixel. When it reaches or exceeds N, the pixel is emitted and N is subtracted. N is cfg_decim_ratio clamped to the range 16 to 112. With decimation off, every pixel is emitted.
- R7: pix_en is high for one cycle in every D cycles. Divider codes 0 to 4 give D = 2 to 6, code 5 gives 8, code 6 gives 16 and code 7 gives 32.
- R8: in_ready is high only on a pix_en cycle with no second byte pending. A word transfers when in_valid and in_ready are both high, and at most one pixel is processed per pix_en cycle.
- R9: out_valid is a one-cycle pulse in the cycle after the enable cycle that processed the emitted pixel. out_sol is high with out_valid on the first pixel emitted after a line start.
- R10: While rst_n is low, out_valid, out_sol and out_data are zero and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 3 | Alignment shift code |
| cfg_pack8 | input | 1 | Two 8-bit pixels per word when high |
| cfg_avg_en | input | 1 | Enables (1,2,1) averaging |
| cfg_decim_en | input | 1 | Enables fractional decimation |
| cfg_decim_ratio | input | 7 | Decimation denominator N (clamped 16..112) |
| cfg_clk_div | input | 3 | Pixel-rate divider code |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle if valid |
| in_data | input | 16 | Word read from memory |
| in_sol | input | 1 | Word is the first of a line |
| pix_en | output | 1 | Pixel-rate enable |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 14 | Output pixel |
| out_sol | output | 1 | Output pixel is the first of its line |

## Verification
A line start can arrive on the same enable cycle as a decision by the decimator to drop a pixel. When that happens, the accumulator clear and the filter history reload must take effect together, and the start marker must move to the next emitted pixel. The bench provokes this by sending lines of random length, with random gaps and ratios above 16, so that start words often land on dropped slots. A behavioural model recomputes each pixel, the accumulator and the pending marker every cycle. The model's expected output is compared with the port values every cycle. Packed phases also put a line start on the cycle right after a pending high byte drains.

// File: rtl/mrd_fmt_pkg.sv
package mrd_fmt_pkg;
    localparam int WORD_W   = 16;
    localparam int PIX_W    = 14;
    localparam int BYTE_W   = WORD_W / 2;
    localparam int DEC_STEP = 16;
    localparam int DEC_MIN  = 16;
    localparam int DEC_MAX  = 112;
    localparam int ACC_W    = $clog2(DEC_MAX + DEC_STEP);
    localparam int DCNT_W   = 5;
    localparam int PAD_W    = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PIX_W-1:0]  pix_t;

    // Align a 16-bit word to PIX_W bits; code 7 folds onto code 6.
    function automatic pix_t align_word(word_t w, logic [2:0] code);
        logic [WORD_W+PAD_W-1:0] ext;
        logic [2:0] c;
        c   = (code == 3'd7) ? 3'd6 : code;
        ext = {w, {PAD_W{1'b0}}};
        ext = ext >> (3'd6 - c);
        return ext[PIX_W-1:0];
    endfunction

    // Terminal count of the divider counter (divide ratio minus one).
    function automatic logic [DCNT_W-1:0] div_limit(logic [2:0] code);
        case (code)
            3'd5:    return DCNT_W'(7);
            3'd6:    return DCNT_W'(15);
            3'd7:    return DCNT_W'(31);
            default: return DCNT_W'(code) + DCNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/mrd_clkdiv.sv
module mrd_clkdiv
    import mrd_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_code,
    output logic       pix_en
);
    typedef struct packed {
        logic [DCNT_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [DCNT_W-1:0] lim;

    always_comb begin
        s_d    = s_q;
        lim    = div_limit(div_code);
        pix_en = (s_q.cnt >= lim);
        s_d.cnt = pix_en ? '0 : s_q.cnt + DCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_EN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en); // R7
endmodule

// File: rtl/mrd_unpack.sv
module mrd_unpack
    import mrd_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_en,
    input  logic        cfg_pack8,
    input  logic [2:0]  cfg_shift,
    input  logic        in_valid,
    input  word_t       in_data,
    input  logic        in_sol,
    output logic        in_ready,
    output logic        px_valid,
    output pix_t        px_data,
    output logic        px_sol
);
    typedef struct packed {
        logic              hold;
        logic [BYTE_W-1:0] hbyte;
    } unp_st_t;

    unp_st_t s_d, s_q;
    word_t   raw;
    logic    take;

    always_comb begin
        s_d      = s_q;
        in_ready = pix_en && !s_q.hold;
        take     = in_ready && in_valid;
        if (s_q.hold)
            raw = {s_q.hbyte, {BYTE_W{1'b0}}};
        else if (cfg_pack8)
            raw = {in_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
        else
            raw = in_data;
        px_valid = pix_en && (s_q.hold || in_valid);
        px_sol   = !s_q.hold && in_sol;
        px_data  = align_word(raw, cfg_shift);
        if (pix_en && s_q.hold)
            s_d.hold = 1'b0;
        if (take && cfg_pack8) begin
            s_d.hold  = 1'b1;
            s_d.hbyte = in_data[WORD_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PAIR_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold && pix_en) |=> !s_q.hold); // R3
    AST_PACK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_pack8) |=> s_q.hold); // R3
endmodule

// File: rtl/mrd_filt_decim.sv
module mrd_filt_decim
    import mrd_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             cfg_avg_en,
    input  logic             cfg_decim_en,
    input  logic [ACC_W-1:0] cfg_ratio,
    input  logic             px_valid,
    input  pix_t             px_data,
    input  logic             px_sol,
    output logic             out_valid,
    output pix_t             out_data,
    output logic             out_sol
);
    typedef struct packed {
        pix_t             h1;
        pix_t             h2;
        logic [ACC_W-1:0] acc;
        logic             pend;
        logic             ov;
        pix_t             od;
        logic             os;
    } fd_st_t;

    fd_st_t s_d, s_q;
    logic [ACC_W-1:0] ratio, acc0, accn;
    logic [PIX_W+1:0] sum;
    pix_t p1, p2, filt;
    logic emit, pend;

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        s_d.os = 1'b0;
        if (cfg_ratio < ACC_W'(DEC_MIN))      ratio = ACC_W'(DEC_MIN);
        else if (cfg_ratio > ACC_W'(DEC_MAX)) ratio = ACC_W'(DEC_MAX);
        else                                  ratio = cfg_ratio;
        p1   = px_sol ? px_data : s_q.h1;
        p2   = px_sol ? px_data : s_q.h2;
        sum  = {2'b00, p2} + {1'b0, p1, 1'b0} + {2'b00, px_data} + (PIX_W+2)'(2);
        filt = cfg_avg_en ? sum[PIX_W+1:2] : px_data;
        pend = px_sol || s_q.pend;
        acc0 = px_sol ? '0 : s_q.acc;
        accn = acc0 + ACC_W'(DEC_STEP);
        emit = 1'b1;
        if (px_valid) begin
            s_d.h1 = px_data;
            s_d.h2 = p1;
            if (!cfg_decim_en) begin
                s_d.acc = '0;
            end else if (accn >= ratio) begin
                s_d.acc = accn - ratio;
            end else begin
                emit    = 1'b0;
                s_d.acc = accn;
            end
            if (emit) begin
                s_d.ov   = 1'b1;
                s_d.od   = filt;
                s_d.os   = pend;
                s_d.pend = 1'b0;
            end else begin
                s_d.pend = pend;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_sol   = s_q.os;

    AST_OUT_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_en)); // R9
    AST_SOL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid); // R9
    AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.acc < ACC_W'(DEC_MAX)); // R6
    AST_NODEC_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !cfg_decim_en) |=> out_valid); // R6
endmodule

// File: rtl/mrd_pix_fmt.sv
module mrd_pix_fmt
    import mrd_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_shift,
    input  logic             cfg_pack8,
    input  logic             cfg_avg_en,
    input  logic             cfg_decim_en,
    input  logic [ACC_W-1:0] cfg_decim_ratio,
    input  logic [2:0]       cfg_clk_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic             in_sol,
    output logic             pix_en,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sol
);
    logic px_valid, px_sol;
    pix_t px_data;

    mrd_clkdiv u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (cfg_clk_div),
        .pix_en   (pix_en)
    );

    mrd_unpack u_unp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .cfg_pack8 (cfg_pack8),
        .cfg_shift (cfg_shift),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sol    (in_sol),
        .in_ready  (in_ready),
        .px_valid  (px_valid),
        .px_data   (px_data),
        .px_sol    (px_sol)
    );

    mrd_filt_decim u_fd (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_en       (pix_en),
        .cfg_avg_en   (cfg_avg_en),
        .cfg_decim_en (cfg_decim_en),
        .cfg_ratio    (cfg_decim_ratio),
        .px_valid     (px_valid),
        .px_data      (px_data),
        .px_sol       (px_sol),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_sol      (out_sol)
    );
endmodule

// File: tb/mrd_pix_fmt_tb.sv
`timescale 1ns/1ps
module mrd_pix_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_shift = '0;
    logic        cfg_pack8 = 1'b0, cfg_avg_en = 1'b0, cfg_decim_en = 1'b0;
    logic [6:0]  cfg_decim_ratio = 7'd16;
    logic [2:0]  cfg_clk_div = '0;
    logic        in_valid = 1'b0, in_sol = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, pix_en, out_valid, out_sol;
    logic [13:0] out_data;

    always #4 clk = ~clk; // 125 MHz

    mrd_pix_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_pack8(cfg_pack8),
        .cfg_avg_en(cfg_avg_en), .cfg_decim_en(cfg_decim_en),
        .cfg_decim_ratio(cfg_decim_ratio), .cfg_clk_div(cfg_clk_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol),
        .pix_en(pix_en), .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string dtag = "";

    // reference model state
    int m_cnt, m_hold, m_hb, h1, h2, acc, pend;
    int exp_v, exp_d, exp_s;
    bit m_accepted;
    int widx, llen;

    function automatic int ref_lim(int c);
        if (c == 5) return 7;
        if (c == 6) return 15;
        if (c == 7) return 31;
        return c + 1;
    endfunction

    function automatic int ref_align(int w, int code);
        int c = (code == 7) ? 6 : code;
        if (c <= 2) return (w >> (2 - c)) & 16'h3FFF;
        return (w << (c - 2)) & 16'h3FFF;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_hold = 0; m_hb = 0; h1 = 0; h2 = 0; acc = 0; pend = 0;
            exp_v = 0; exp_d = 0; exp_s = 0; m_accepted = 0;
        end else begin
            bit pe, have, sl;
            int raw, p, f, n;
            pe = (m_cnt >= ref_lim(cfg_clk_div));
            have = 0; sl = 0; raw = 0;
            if (pe) begin
                if (m_hold != 0) begin
                    raw = m_hb << 8; have = 1; m_hold = 0;
                end else if (in_valid) begin
                    have = 1; sl = in_sol; m_accepted = 1;
                    if (cfg_pack8) begin
                        raw = (in_data & 255) << 8; m_hb = in_data >> 8; m_hold = 1;
                    end else raw = in_data;
                end
            end
            m_cnt = pe ? 0 : m_cnt + 1;
            exp_v = 0; exp_s = 0;
            if (have) begin
                bit emit;
                p = ref_align(raw, cfg_shift);
                if (sl) begin h1 = p; h2 = p; acc = 0; end
                f = cfg_avg_en ? (h2 + 2*h1 + p + 2) / 4 : p;
                h2 = h1; h1 = p;
                n = cfg_decim_ratio < 16 ? 16 : (cfg_decim_ratio > 112 ? 112 : cfg_decim_ratio);
                emit = 1;
                if (cfg_decim_en) begin
                    acc += 16;
                    if (acc >= n) acc -= n; else emit = 0;
                end
                if (sl) pend = 1;
                if (emit) begin
                    exp_v = 1; exp_d = f; exp_s = pend; pend = 0;
                end
            end
        end
    end

    task automatic step();
        int rdy;
        rdy = (m_cnt >= ref_lim(cfg_clk_div)) && (m_hold == 0);
        chk("R9 valid", out_valid, exp_v);
        chk("R7 R8 ready", in_ready, rdy);
        if (exp_v) begin
            chk({dtag, " data"}, out_data, exp_d);
            chk("R9 sol", out_sol, exp_s);
        end
        if (!in_valid || m_accepted) begin
            if ($urandom % 4 != 0) begin
                in_valid = 1; in_data = $urandom; in_sol = (widx == 0);
                widx++;
                if (widx >= llen) begin widx = 0; llen = 3 + $urandom % 15; end
            end else begin
                in_valid = 0; in_sol = 0;
            end
        end
        m_accepted = 0;
    endtask

    task automatic run_phase(int sh, int pk, int av, int de, int ra, int dv, int cyc);
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_sol = 0;
        cfg_shift = sh; cfg_pack8 = pk; cfg_avg_en = av; cfg_decim_en = de;
        cfg_decim_ratio = ra; cfg_clk_div = dv;
        dtag = $sformatf("%s %s%s%s", (sh <= 2) ? "R1" : "R2", pk ? "R3" : "R4",
                         av ? " R5" : "", de ? " R6" : "");
        widx = 0; llen = 8;
        repeat (3) @(negedge clk);
        chk("R10 out_valid", out_valid, 0);
        chk("R10 out_sol", out_sol, 0);
        chk("R10 out_data", out_data, 0);
        chk("R10 in_ready", in_ready, 0);
        rst_n = 1;
        repeat (cyc) begin
            @(negedge clk);
            step();
        end
    endtask

    initial begin
        run_phase(0, 0, 0, 0, 16,  0, 3000);
        run_phase(3, 1, 0, 0, 16,  1, 3000);
        run_phase(6, 0, 1, 0, 16,  2, 3000);
        run_phase(2, 0, 1, 1, 24,  0, 4000);
        run_phase(1, 1, 0, 1, 112, 5, 4000);
        run_phase(7, 0, 0, 1, 5,   7, 6000);
        run_phase(4, 1, 1, 1, 127, 6, 6000);
        run_phase(5, 0, 1, 1, 40,  3, 4000);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule